// File: doc/BRIEF.md
# Set-Associative Address Translation Lookup

This block translates a 32-bit virtual address into a physical address for a processor whose translation buffer is filled by software. Pages are 4 KB. The low bits of the virtual page number select one set. Every way of that set is compared in parallel against the page number and the current process identifier. One clock later the block reports either a hit or a miss.

A hit returns three things:
- the physical address, which is the entry's frame number with the page offset appended;
- the entry's read, write and execute permissions;
- a fault flag, raised when the requested kind of access is not allowed.

The entries are held inside the block. A single write port fills them by way and set. Refill policy, exception handling and any register view of the entries are left to the surrounding logic.

Top module: `tlb_lookup`

## Requirements
- R1: After reset every entry is invalid. Every lookup misses until an entry is written, and `rsp_valid`, `rsp_hit` and `rsp_miss` are low while reset is held.
- R2: A lookup presented with `req_valid` high at a clock edge is reported after that edge, with `rsp_valid` high for exactly one cycle. Without a request, `rsp_valid`, `rsp_hit`, `rsp_miss` and `rsp_fault` are low, and `rsp_paddr`, `rsp_perm` and `rsp_way` are zero.
- R3: A tag word is laid out as follows: page number in bits 31:12, global flag in bit 11, valid flag in bit 10, process ID in bits PID_BITS-1:0. An entry hits when three conditions hold:
  - its valid flag is set;
  - its page number equals `req_vaddr[31:12]`;
  - its global flag is set, or its process ID equals `cur_pid`.
- R4: The set searched is the request page number ANDed with (NUM_ENTRIES/NUM_WAYS)-1. The write port stores into entry `wr_way`*(NUM_ENTRIES/NUM_WAYS)+`wr_set`. A hit reports its way on `rsp_way`.
- R5: A data word is laid out as follows: frame number in bits 19:0, execute flag in bit 20, write flag in bit 21, read flag in bit 22, cacheable flag in bit 23. On a hit, `rsp_paddr` is the frame number shifted left by 12, ORed with `req_vaddr[11:0]`.
- R6: On a hit, `rsp_perm` is {read, write, execute} of the entry (bit 2 is read). The cacheable flag has no effect on any output.
- R7: `req_acc` is encoded 0 = read, 1 = write, 2 = instruction fetch, 3 = reserved. On a hit, `rsp_fault` is high when the flag the access needs is clear, and it is always high for code 3.
- R8: When several ways hit, the lowest-numbered way supplies the result.
- R9: On a miss, `rsp_miss` is high, `rsp_hit` is low, and `rsp_paddr`, `rsp_perm`, `rsp_fault` and `rsp_way` are zero.
- R10: A lookup in the same cycle as a write sees the entries as they were before the write. The write is visible to lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all entries |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| cur_pid | input | PID_BITS | Current process identifier |
| wr_en | input | 1 | Write one entry |
| wr_way | input | $clog2(NUM_WAYS) | Way to write |
| wr_set | input | $clog2(NUM_ENTRIES/NUM_WAYS) | Set to write |
| wr_tag | input | 32 | Tag word to store |
| wr_data | input | 32 | Data word to store |
| rsp_valid | output | 1 | Result present |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | No way matched |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | {read, write, execute} |
| rsp_fault | output | 1 | Access not permitted by a hitting entry |
| rsp_way | output | $clog2(NUM_WAYS) | Way that supplied the result |

## Verification
A corrupted entry, a wrong set index or a wrong way priority is not visible at the ports until a lookup touches that set. The symptom appears one cycle after that request, as a wrong hit or miss, a wrong frame or way, or a spurious fault. The bench therefore keeps its own copy of every entry. It compares every output on every cycle against that copy, and it directs lookups at each set and way it has written, so any divergence in storage shows up the cycle after the first lookup that reaches it.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W     = 32;
    localparam int PG_BITS  = 12;
    localparam int VPN_W    = VA_W - PG_BITS;
    localparam int PFN_W    = 20;
    localparam int T_GLOBAL = 11;
    localparam int T_VALID  = 10;
    localparam int D_EXEC   = 20;
    localparam int D_WRITE  = 21;
    localparam int D_READ   = 22;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
    parameter int NUM_WAYS    = 4,
    parameter int NUM_ENTRIES = 32
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      wr_en,
    input  logic [$clog2(NUM_WAYS)-1:0]               wr_way,
    input  logic [$clog2(NUM_ENTRIES/NUM_WAYS)-1:0]   wr_set,
    input  logic [31:0]                               wr_tag,
    input  logic [31:0]                               wr_data,
    input  logic [$clog2(NUM_ENTRIES/NUM_WAYS)-1:0]   rd_set,
    output logic [NUM_WAYS-1:0][31:0]                 rd_tag,
    output logic [NUM_WAYS-1:0][31:0]                 rd_data
);
    localparam int WAY_W = $clog2(NUM_WAYS);
    localparam int IDX_W = $clog2(NUM_ENTRIES);

    logic [31:0]      tag_d  [NUM_ENTRIES];
    logic [31:0]      tag_q  [NUM_ENTRIES];
    logic [31:0]      data_d [NUM_ENTRIES];
    logic [31:0]      data_q [NUM_ENTRIES];
    logic [IDX_W-1:0] widx;

    // Way-major indexing: way * sets + set (sets is a power of two).
    assign widx = {wr_way, wr_set};

    always_comb begin
        tag_d  = tag_q;
        data_d = data_q;
        if (wr_en) begin
            tag_d[widx]  = wr_tag;
            data_d[widx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q  <= '{default: '0};
            data_q <= '{default: '0};
        end else begin
            tag_q  <= tag_d;
            data_q <= data_d;
        end
    end

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rd
        localparam logic [WAY_W-1:0] WI = WAY_W'(w);
        assign rd_tag[w]  = tag_q[{WI, rd_set}];
        assign rd_data[w] = data_q[{WI, rd_set}];
    end

    // R4: a write lands in the addressed slot.
    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tag_q[$past(widx)] == $past(wr_tag)) && (data_q[$past(widx)] == $past(wr_data)));
endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match #(
    parameter int PID_BITS = 8
) (
    input  logic [31:0]          tag,
    input  logic [19:0]          req_vpn,
    input  logic [PID_BITS-1:0]  cur_pid,
    output logic                 hit
);
    import tlb_pkg::*;

    logic vpn_eq, pid_ok;

    always_comb begin
        vpn_eq = (tag[31:PG_BITS] == req_vpn);
        pid_ok = tag[T_GLOBAL] || (tag[PID_BITS-1:0] == cur_pid);
        hit    = tag[T_VALID] && vpn_eq && pid_ok;
    end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int NUM_WAYS = 4
) (
    input  logic [NUM_WAYS-1:0]         hits,
    output logic                        any,
    output logic [$clog2(NUM_WAYS)-1:0] sel
);
    localparam int WAY_W = $clog2(NUM_WAYS);

    always_comb begin
        any = |hits;
        sel = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (hits[w]) sel = WAY_W'(w);
        end
    end
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup #(
    parameter int NUM_WAYS    = 4,
    parameter int NUM_ENTRIES = 32,
    parameter int PID_BITS    = 8
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      req_valid,
    input  logic [31:0]                               req_vaddr,
    input  logic [1:0]                                req_acc,
    input  logic [PID_BITS-1:0]                       cur_pid,
    input  logic                                      wr_en,
    input  logic [$clog2(NUM_WAYS)-1:0]               wr_way,
    input  logic [$clog2(NUM_ENTRIES/NUM_WAYS)-1:0]   wr_set,
    input  logic [31:0]                               wr_tag,
    input  logic [31:0]                               wr_data,
    output logic                                      rsp_valid,
    output logic                                      rsp_hit,
    output logic                                      rsp_miss,
    output logic [31:0]                               rsp_paddr,
    output logic [2:0]                                rsp_perm,
    output logic                                      rsp_fault,
    output logic [$clog2(NUM_WAYS)-1:0]               rsp_way
);
    import tlb_pkg::*;

    localparam int WAY_W = $clog2(NUM_WAYS);
    localparam int SETS  = NUM_ENTRIES / NUM_WAYS;
    localparam int SET_W = $clog2(SETS);

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic             miss;
        logic [31:0]      paddr;
        logic [2:0]       perm;
        logic             fault;
        logic [WAY_W-1:0] way;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [19:0]                 req_vpn;
    logic [SET_W-1:0]            rd_set;
    logic [NUM_WAYS-1:0][31:0]   rd_tag;
    logic [NUM_WAYS-1:0][31:0]   rd_data;
    logic [NUM_WAYS-1:0]         hit_vec;
    logic                        any_hit;
    logic [WAY_W-1:0]            sel_way;
    logic [31:0]                 sel_data;

    assign req_vpn = req_vaddr[31:PG_BITS];
    assign rd_set  = req_vpn[SET_W-1:0];

    tlb_store #(.NUM_WAYS(NUM_WAYS), .NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_way(wr_way), .wr_set(wr_set),
        .wr_tag(wr_tag), .wr_data(wr_data), .rd_set(rd_set),
        .rd_tag(rd_tag), .rd_data(rd_data)
    );

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        tlb_way_match #(.PID_BITS(PID_BITS)) u_match (
            .tag(rd_tag[w]), .req_vpn(req_vpn), .cur_pid(cur_pid), .hit(hit_vec[w])
        );
    end

    tlb_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
        .hits(hit_vec), .any(any_hit), .sel(sel_way)
    );

    assign sel_data = rd_data[sel_way];

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (any_hit) begin
                rsp_d.hit   = 1'b1;
                rsp_d.way   = sel_way;
                rsp_d.paddr = {sel_data[PFN_W-1:0], req_vaddr[PG_BITS-1:0]};
                rsp_d.perm  = {sel_data[D_READ], sel_data[D_WRITE], sel_data[D_EXEC]};
                unique case (acc_e'(req_acc))
                    ACC_READ:  rsp_d.fault = !sel_data[D_READ];
                    ACC_WRITE: rsp_d.fault = !sel_data[D_WRITE];
                    ACC_FETCH: rsp_d.fault = !sel_data[D_EXEC];
                    default:   rsp_d.fault = 1'b1;
                endcase
            end else begin
                rsp_d.miss = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_miss  = rsp_q.miss;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_perm  = rsp_q.perm;
    assign rsp_fault = rsp_q.fault;
    assign rsp_way   = rsp_q.way;

    logic [NUM_WAYS-1:0] below_sel;
    assign below_sel = (NUM_WAYS'(1) << sel_way) - NUM_WAYS'(1);

    assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_resp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_hit && !rsp_miss);
    assert_hit_xor_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit ^ rsp_miss));
    assert_miss_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_paddr == '0) && (rsp_perm == '0) && !rsp_fault);
    assert_fault_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_hit);
    assert_offset_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_paddr[PG_BITS-1:0] == $past(req_vaddr[PG_BITS-1:0])));
    assert_lowest_way_R8: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> hit_vec[sel_way] && ((hit_vec & below_sel) == '0));
endmodule

// File: tb/tb_tlb_lookup.sv
module tb_tlb_lookup;
    localparam int WAYS    = 4;
    localparam int ENTRIES = 32;
    localparam int SETS    = ENTRIES / WAYS;
    localparam int PIDB    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic [7:0]  cur_pid = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_way = '0;
    logic [2:0]  wr_set = '0;
    logic [31:0] wr_tag = '0;
    logic [31:0] wr_data = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_perm;
    logic [1:0]  rsp_way;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] m_tag  [ENTRIES];
    logic [31:0] m_data [ENTRIES];

    logic        e_valid, e_hit, e_miss, e_fault;
    logic [31:0] e_paddr;
    logic [2:0]  e_perm;
    logic [1:0]  e_way;

    always #4 clk = ~clk;

    tlb_lookup #(.NUM_WAYS(WAYS), .NUM_ENTRIES(ENTRIES), .PID_BITS(PIDB)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .cur_pid(cur_pid), .wr_en(wr_en), .wr_way(wr_way),
        .wr_set(wr_set), .wr_tag(wr_tag), .wr_data(wr_data), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr),
        .rsp_perm(rsp_perm), .rsp_fault(rsp_fault), .rsp_way(rsp_way)
    );

    function automatic logic [31:0] mk_tag(logic [19:0] vpn, bit g, bit v, logic [7:0] pid);
        return {vpn, g, v, 2'b00, pid};
    endfunction

    function automatic logic [31:0] mk_data(bit c, bit r, bit w, bit x, logic [19:0] pfn);
        return {8'h00, c, r, w, x, pfn};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected result from the requirements and the bench's copy of the entries.
    task automatic predict(bit rv, logic [31:0] va, logic [1:0] acc, logic [7:0] pid);
        logic [19:0] vpn;
        bit found;
        vpn = va[31:12];
        found = 0;
        e_valid = rv; e_hit = 0; e_miss = 0; e_fault = 0;
        e_paddr = '0; e_perm = '0; e_way = '0;
        if (rv) begin
            for (int w = 0; w < WAYS && !found; w++) begin
                int idx;
                logic [31:0] t, d;
                idx = w * SETS + int'(vpn) % SETS;
                t = m_tag[idx];
                d = m_data[idx];
                if (t[10] && t[31:12] == vpn && (t[11] || t[7:0] == pid)) begin
                    found = 1;
                    e_hit = 1;
                    e_way = 2'(w);
                    e_paddr = (d & 32'h000F_FFFF) * 4096 + (va % 4096);
                    e_perm = {d[22], d[21], d[20]};
                    if (acc == 0)      e_fault = !d[22];
                    else if (acc == 1) e_fault = !d[21];
                    else if (acc == 2) e_fault = !d[20];
                    else               e_fault = 1;
                end
            end
            if (!found) e_miss = 1;
        end
    endtask

    task automatic step(string req, bit rv, logic [31:0] va, logic [1:0] acc, logic [7:0] pid,
                        bit we, int way, int set, logic [31:0] tg, logic [31:0] dt);
        req_valid = rv; req_vaddr = va; req_acc = acc; cur_pid = pid;
        wr_en = we; wr_way = 2'(way); wr_set = 3'(set); wr_tag = tg; wr_data = dt;
        predict(rv, va, acc, pid);
        @(posedge clk);
        if (we) begin
            m_tag[way * SETS + set]  = tg;
            m_data[way * SETS + set] = dt;
        end
        @(negedge clk);
        chk(req, "valid", 32'(rsp_valid), 32'(e_valid));
        chk(req, "hit",   32'(rsp_hit),   32'(e_hit));
        chk(req, "miss",  32'(rsp_miss),  32'(e_miss));
        chk(req, "paddr", rsp_paddr,      e_paddr);
        chk(req, "perm",  32'(rsp_perm),  32'(e_perm));
        chk(req, "fault", 32'(rsp_fault), 32'(e_fault));
        chk(req, "way",   32'(rsp_way),   32'(e_way));
    endtask

    task automatic look(string req, logic [31:0] va, logic [1:0] acc, logic [7:0] pid);
        step(req, 1, va, acc, pid, 0, 0, 0, '0, '0);
    endtask

    task automatic put(string req, int way, int set, logic [31:0] tg, logic [31:0] dt);
        step(req, 0, '0, 0, 0, 1, way, set, tg, dt);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin m_tag[i] = '0; m_data[i] = '0; end
        repeat (3) @(negedge clk);
        chk("R1", "reset valid", 32'(rsp_valid), 0);
        chk("R1", "reset hit",   32'(rsp_hit),   0);
        chk("R1", "reset miss",  32'(rsp_miss),  0);
        rst_n = 1'b1;
        @(negedge clk);

        look("R1", 32'h0000_0123, 0, 8'd0);
        look("R1", 32'h0040_37F4, 0, 8'd5);
        step("R2", 0, 32'h0040_37F4, 0, 8'd5, 0, 0, 0, '0, '0);

        // R4: way 0, set 3, vpn 0x00403, pid 5, read+write.
        put("R4", 0, 3, mk_tag(20'h00403, 0, 1, 8'd5), mk_data(0, 1, 1, 0, 20'hABCDE));
        look("R3", 32'h0040_37F4, 0, 8'd5);
        look("R3", 32'h0040_37F4, 0, 8'd6);
        look("R5", 32'h0040_3001, 1, 8'd5);
        look("R7", 32'h0040_3FFF, 2, 8'd5);
        look("R7", 32'h0040_3010, 3, 8'd5);

        // Global entry in way 1 of the same set.
        put("R3", 1, 3, mk_tag(20'h00403, 1, 1, 8'd9), mk_data(1, 0, 0, 1, 20'h11111));
        look("R3", 32'h0040_3ABC, 2, 8'd6);
        look("R7", 32'h0040_3ABC, 0, 8'd6);
        look("R8", 32'h0040_3ABC, 0, 8'd5);
        look("R6", 32'h0040_3000, 2, 8'd77);

        // Invalid entry never hits.
        put("R3", 2, 6, mk_tag(20'h12346, 1, 0, 8'd0), mk_data(0, 1, 1, 1, 20'h22222));
        look("R3", 32'h1234_6000, 0, 8'd0);

        // Set index from low page bits, way reported.
        put("R4", 2, 6, mk_tag(20'h07F0E, 0, 1, 8'd3), mk_data(0, 1, 0, 1, 20'h0F0F0));
        look("R4", 32'h07F0_E123, 0, 8'd3);
        look("R4", 32'h0000_E123, 0, 8'd3);

        // Same-cycle write and lookup.
        step("R10", 1, 32'h0005_5444, 0, 8'd1, 1, 3, 5, mk_tag(20'h00055, 0, 1, 8'd1),
             mk_data(0, 1, 0, 0, 20'h33333));
        look("R10", 32'h0005_5444, 0, 8'd1);
        look("R10", 32'h0005_5444, 1, 8'd1);

        // Random traffic against the reference copy.
        for (int n = 0; n < 400; n++) begin
            logic [19:0] vpn;
            logic [31:0] d;
            vpn = 20'($urandom_range(0, 15)) | (20'($urandom_range(0, 1)) << 12);
            d = $urandom & 32'h00FF_FFFF;
            step("R3", 1'($urandom_range(0, 1)), {vpn, 12'($urandom)}, 2'($urandom),
                 8'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0),
                 $urandom_range(0, WAYS - 1), int'(vpn) % SETS,
                 mk_tag(vpn, 1'($urandom_range(0, 1)), ($urandom_range(0, 4) != 0),
                        8'($urandom_range(0, 3))), d);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule